// File: doc/BRIEF.md
# Reloadable Up/Down Event Timer

This block is an 8-bit timer that counts up or down on strobes from a chosen source. A 3-bit source code picks one of six divided taps of the system clock, a divided sub-clock tap, or edges on an external event pin. The prescaler chain lives outside the block, and each tap arrives as a one-cycle strobe. The external pin is asynchronous, so the block synchronizes it and then detects the selected edge.

When the counter wraps, it either continues freely (interval mode) or takes the value held in a load register (auto-reload mode). Every wrap raises a sticky interrupt request flag. Software clears the flag. A small register port offers three locations: a mode register, a shared count/load location, and a flag register. At the shared location, reads return the live count and writes go to the load register, which also presets the counter.

Top module: `updown_reload_timer`

## Requirements
- R1: After reset the count reads 0x00, the flag register reads 0x00, `irq_o` is 0, and the mode register (address 0) reads 0x18 (source code 000, all control bits 0).
- R2: Source codes 000 to 101 in mode bits [2:0] select `tick_in[code]` (divide by 8192, 2048, 512, 64, 16, 4). The counter takes one step in the cycle after a strobe of the selected tap, and strobes on other taps leave it unchanged.
- R3: Source code 110 selects `sub_tick`, the divided sub-clock strobe.
- R4: Source code 111 counts edges of `ext_evt`. Mode bit 5 chooses the edge: 0 for rising, 1 for falling. The pin passes through a two-flop synchronizer, so a pin change that is set up before clock edge n is counted at edge n+2. The opposite edge is not counted.
- R5: With mode bit 6 = 0 (up) and bit 7 = 0 (interval), a step from 0xFF gives 0x00.
- R6: With mode bit 6 = 1 (down) and bit 7 = 0, a step from 0x00 gives 0xFF.
- R7: With mode bit 7 = 1 (auto-reload), a wrap in either direction loads the counter from the load register.
- R8: Every wrap sets the flag (bit 0 at address 2, and `irq_o`) in the following cycle. The flag stays set.
- R9: Writing 0 to bit 0 at address 2 clears the flag, and writing 1 has no effect. If a clear and a wrap fall in the same cycle, the flag stays set.
- R10: At address 1, a read returns the live count. A write stores the load register and presets the counter to the written value, and it takes priority over a step in the same cycle.
- R11: Mode bits [4:3] always read as 1 and ignore writes.
- R12: The counter changes only on a load write or a strobe of the selected source, and by at most one step per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 6 | System-clock prescaler strobes, index = source code |
| sub_tick | input | 1 | Sub-clock divide-by-4 strobe |
| ext_evt | input | 1 | Asynchronous external event pin |
| addr | input | 2 | Register address: 0 mode, 1 count/load, 2 flag |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
The assertions assume that the prescaler strobes are single-cycle pulses synchronous to `clk`, and that register writes are single-cycle `wr_en` pulses with stable address and data. They also assume that `ext_evt` may change at any time but is only observed through the synchronizer. The bench drives every input on the falling clock edge and holds each strobe for exactly one cycle. It keeps the external pin steady for several cycles between changes, so that each edge is seen exactly once.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W   = 8;
  localparam int SRC_W   = 3;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] A_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_FLAG = 2'd2;

  typedef struct packed {
    logic             reload_en;  // bit 7
    logic             down;       // bit 6
    logic             fall_edge;  // bit 5
    logic [SRC_W-1:0] src;        // bits 2:0
  } tmr_mode_t;

  localparam logic [SRC_W-1:0] SRC_SUB = 3'd6;
  localparam logic [SRC_W-1:0] SRC_EXT = 3'd7;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
  import tmr_pkg::*;
#(
  parameter int SYS_TAPS    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SYS_TAPS-1:0] tick_in,
  input  logic                sub_tick,
  input  logic                ext_evt,
  input  logic [SRC_W-1:0]    src,
  input  logic                fall_edge,
  output logic                step
);
  localparam int N_SRC = 1 << SRC_W;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic                   ext_edge;
  logic [N_SRC-1:0]       taps;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], ext_evt};
    prev_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign ext_edge = fall_edge ? (prev_q & ~sync_q[SYNC_STAGES-1])
                              : (~prev_q & sync_q[SYNC_STAGES-1]);

  genvar gi;
  generate
    for (gi = 0; gi < N_SRC; gi++) begin : g_tap
      if (gi < SYS_TAPS) begin : g_sys
        assign taps[gi] = tick_in[gi];
      end else if (gi == int'(SRC_SUB)) begin : g_sub
        assign taps[gi] = sub_tick;
      end else if (gi == int'(SRC_EXT)) begin : g_ext
        assign taps[gi] = ext_edge;
      end else begin : g_none
        assign taps[gi] = 1'b0;
      end
    end
  endgenerate

  assign step = taps[src];
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         down,
  input  logic         reload_en,
  input  logic         load_we,
  input  logic [W-1:0] load_wdata,
  input  logic [W-1:0] load_q,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  localparam logic [W-1:0] CNT_MIN = '0;

  logic [W-1:0] cnt_q, cnt_d;
  logic         at_edge;
  logic         cnt_en;

  assign at_edge = down ? (cnt_q == CNT_MIN) : (cnt_q == CNT_MAX);
  assign wrap_o  = step & ~load_we & at_edge;
  assign cnt_en  = load_we | step;

  always_comb begin
    cnt_d = cnt_q;
    if (load_we) begin
      cnt_d = load_wdata;
    end else if (step) begin
      if (at_edge && reload_en) cnt_d = load_q;
      else if (down)            cnt_d = cnt_q - 1'b1;
      else                      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrap,
  output tmr_mode_t         mode,
  output logic [CNT_W-1:0]  load_q,
  output logic              load_we,
  output logic              flag_clr,
  output logic              flag,
  output logic [CNT_W-1:0]  rd_data
);
  tmr_mode_t        mode_q, mode_d;
  logic [CNT_W-1:0] load_d;
  logic             flag_q, flag_d;
  logic             mode_we;

  assign mode_we  = wr_en && (addr == A_MODE);
  assign load_we  = wr_en && (addr == A_CNT);
  assign flag_clr = wr_en && (addr == A_FLAG) && !wr_data[0];

  always_comb begin
    mode_d = mode_q;
    if (mode_we) begin
      mode_d.reload_en = wr_data[7];
      mode_d.down      = wr_data[6];
      mode_d.fall_edge = wr_data[5];
      mode_d.src       = wr_data[SRC_W-1:0];
    end
    load_d = load_we ? wr_data : load_q;
    if (wrap)          flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      load_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (mode_we) mode_q <= mode_d;
      if (load_we) load_q <= load_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    case (addr)
      A_MODE:  rd_data = {mode_q.reload_en, mode_q.down, mode_q.fall_edge,
                          2'b11, mode_q.src};
      A_CNT:   rd_data = cnt;
      A_FLAG:  rd_data = {{(CNT_W-1){1'b0}}, flag_q};
      default: rd_data = '0;
    endcase
  end

  assign mode = mode_q;
  assign flag = flag_q;
endmodule

// File: rtl/updown_reload_timer.sv
module updown_reload_timer
  import tmr_pkg::*;
#(
  parameter int SYS_TAPS    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SYS_TAPS-1:0] tick_in,
  input  logic                sub_tick,
  input  logic                ext_evt,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [CNT_W-1:0]    wr_data,
  output logic [CNT_W-1:0]    rd_data,
  output logic                irq_o
);
  logic             rst_n_sync;
  tmr_mode_t        mode;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] cnt;
  logic             load_we;
  logic             flag_clr;
  logic             step;
  logic             wrap;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  tmr_src_sel #(.SYS_TAPS(SYS_TAPS), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n_sync), .tick_in(tick_in), .sub_tick(sub_tick),
    .ext_evt(ext_evt), .src(mode.src), .fall_edge(mode.fall_edge), .step(step)
  );

  tmr_count_core #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_sync), .step(step), .down(mode.down),
    .reload_en(mode.reload_en), .load_we(load_we), .load_wdata(wr_data),
    .load_q(load_q), .cnt_o(cnt), .wrap_o(wrap)
  );

  tmr_regs u_regs (
    .clk(clk), .rst_n(rst_n_sync), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .cnt(cnt), .wrap(wrap), .mode(mode), .load_q(load_q),
    .load_we(load_we), .flag_clr(flag_clr), .flag(irq_o), .rd_data(rd_data)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rst_n_sync,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  rd_data,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  load_q,
  input logic              step,
  input logic              wrap,
  input logic              load_we,
  input logic              flag_clr,
  input logic              down,
  input logic              reload_en,
  input logic              irq_o
);
  // R8: a wrap raises the flag on the next cycle
  a_r8_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n_sync)
    wrap |=> irq_o);

  // R9: the flag holds unless software clears it
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (irq_o && !flag_clr) |=> irq_o);

  // R12: no step and no load leaves the count alone
  a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!step && !load_we) |=> $stable(cnt));

  // R5: interval up-count wraps to zero
  a_r5_up_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (step && !load_we && !down && !reload_en && cnt == 8'hFF) |=> cnt == 8'h00);

  // R6: interval down-count wraps to all ones
  a_r6_down_wrap_max: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (step && !load_we && down && !reload_en && cnt == 8'h00) |=> cnt == 8'hFF);

  // R7: auto-reload wrap takes the load register value
  a_r7_reload_value: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wrap && reload_en) |=> cnt == $past(load_q));

  // R11: reserved mode bits read as ones
  a_r11_reserved_ones: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (addr == A_MODE) |-> rd_data[4:3] == 2'b11);
endmodule

bind updown_reload_timer tmr_chk u_chk (
  .clk(clk), .rst_n_sync(rst_n_sync), .addr(addr), .rd_data(rd_data),
  .cnt(cnt), .load_q(load_q), .step(step), .wrap(wrap), .load_we(load_we),
  .flag_clr(flag_clr), .down(mode.down), .reload_en(mode.reload_en),
  .irq_o(irq_o)
);

// File: tb/updown_reload_timer_test.sv
module updown_reload_timer_test;
  logic       clk;
  logic       rst_n;
  logic [5:0] tick_in;
  logic       sub_tick;
  logic       ext_evt;
  logic [1:0] addr;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  updown_reload_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .sub_tick(sub_tick),
    .ext_evt(ext_evt), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {src[2:0], tap[2:0], expect_step}; tap 6 = sub_tick
  localparam logic [6:0] VEC [0:7] = '{
    {3'd0, 3'd0, 1'b1}, {3'd0, 3'd1, 1'b0},
    {3'd3, 3'd3, 1'b1}, {3'd3, 3'd2, 1'b0},
    {3'd5, 3'd5, 1'b1}, {3'd5, 3'd4, 1'b0},
    {3'd6, 3'd6, 1'b1}, {3'd6, 3'd5, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic pulse(input int tap);
    @(negedge clk);
    if (tap < 6) tick_in[tap] = 1'b1;
    else if (tap == 6) sub_tick = 1'b1;
    @(negedge clk);
    tick_in = '0; sub_tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; tick_in = '0; sub_tick = 1'b0; ext_evt = 1'b0;
    addr = '0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 mode", v, 8'h18);
    rd(2'd1, v); check("R1 count", v, 8'h00);
    rd(2'd2, v); check("R1 flag", v, 8'h00);
    check("R1 irq", {7'd0, irq_o}, 8'h00);

    // R2/R3/R12 source selection table
    for (int i = 0; i < 8; i++) begin
      logic [2:0] src, tap;
      logic       ex;
      {src, tap, ex} = VEC[i];
      wr(2'd0, {5'b0, src});
      wr(2'd1, 8'h10);
      pulse(int'(tap));
      rd(2'd1, v);
      check((src == 3'd6) ? "R3 sub tap" : "R2 R12 sys tap", v, 8'h10 + {7'd0, ex});
    end

    // R11 reserved bits
    wr(2'd0, 8'hE7); rd(2'd0, v); check("R11 set", v, 8'hFF);
    wr(2'd0, 8'h00); rd(2'd0, v); check("R11 clr", v, 8'h18);

    // R5 up interval wrap, R8 flag
    wr(2'd0, 8'h05); wr(2'd1, 8'hFF); pulse(5);
    rd(2'd1, v); check("R5 up wrap", v, 8'h00);
    check("R8 irq", {7'd0, irq_o}, 8'h01);
    pulse(5); rd(2'd2, v); check("R8 sticky", v, 8'h01);

    // R9 clear semantics
    wr(2'd2, 8'h01); rd(2'd2, v); check("R9 write1", v, 8'h01);
    wr(2'd2, 8'h00); rd(2'd2, v); check("R9 clear", v, 8'h00);

    // R6 down interval wrap
    wr(2'd0, 8'h45); wr(2'd1, 8'h00); pulse(5);
    rd(2'd1, v); check("R6 down wrap", v, 8'hFF);
    rd(2'd2, v); check("R6 R8 flag", v, 8'h01);

    // R9 set wins over clear
    wr(2'd1, 8'hFF);
    @(negedge clk);
    addr = 2'd2; wr_data = 8'h00; wr_en = 1'b1; tick_in[5] = 1'b0;
    wr_en = 1'b0;
    wr(2'd0, 8'h05); wr(2'd1, 8'hFF);
    @(negedge clk);
    addr = 2'd2; wr_data = 8'h00; wr_en = 1'b1; tick_in[5] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_in = '0;
    rd(2'd2, v); check("R9 set wins", v, 8'h01);

    // R7 auto-reload up and down
    wr(2'd0, 8'h85); wr(2'd1, 8'hFE);
    pulse(5); rd(2'd1, v); check("R7 up pre", v, 8'hFF);
    pulse(5); rd(2'd1, v); check("R7 up reload", v, 8'hFE);
    wr(2'd0, 8'hC5); wr(2'd1, 8'h01);
    pulse(5); rd(2'd1, v); check("R7 down pre", v, 8'h00);
    pulse(5); rd(2'd1, v); check("R7 down reload", v, 8'h01);

    // R10 load write beats a step
    wr(2'd0, 8'h05);
    @(negedge clk);
    addr = 2'd1; wr_data = 8'h33; wr_en = 1'b1; tick_in[5] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_in = '0;
    rd(2'd1, v); check("R10 load priority", v, 8'h33);

    // R4 external event, rising then falling
    wr(2'd0, 8'h07); wr(2'd1, 8'h00);
    @(negedge clk); ext_evt = 1'b1; addr = 2'd1;
    @(negedge clk); @(negedge clk);
    #1 check("R4 rise latency", rd_data, 8'h00);
    @(negedge clk);
    #1 check("R4 rise count", rd_data, 8'h01);
    @(negedge clk); ext_evt = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd1, v); check("R4 fall ignored", v, 8'h01);
    wr(2'd0, 8'h27);
    @(negedge clk); ext_evt = 1'b1;
    repeat (5) @(negedge clk);
    rd(2'd1, v); check("R4 rise ignored", v, 8'h01);
    @(negedge clk); ext_evt = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd1, v); check("R4 fall count", v, 8'h02);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule